// File: doc/BRIEF.md
# Transfer-Record Control Register Bank

This block holds the configuration word for a per-hart facility that records control transfers (branches, jumps, calls, returns, traps). One 64-bit storage word is owned by machine mode. Supervisor software reaches the same word through a second address. That view masks out the two bits that only machine mode may control. A third address holds a separate guest copy for a virtualized supervisor. While the virtualization flag is set, accesses to the supervisor address are steered to this guest copy.

The block sits behind a simple CSR port: select, write enable, address, write data and a combinational read data path. It also takes the current privilege level and the virtualization flag. It checks each access against the privilege level and flags the illegal ones. It drives every field of both stored words out as decoded signals, so the recording logic can use them directly.

Top module: `xfer_rec_ctl_bank`

## Requirements
- R1: The block maps three addresses: the machine word at 0x34E, the supervisor view at 0x14E and the guest copy at 0x24E. An access to any other address reads zero, does not raise `csr_illegal` and changes no state.
- R2: The machine word implements only these bits: 0, 1, 2, 7, 8, 9, 11, 12, 33..37, 40..47 and 60..63. This gives the mask 0xF000_FF3E_0000_1B87. A write at 0x34E stores `wdata` under this mask, and every other bit reads as zero.
- R3: A read at 0x14E with the virtualization flag clear returns the machine word with bits 2 and 9 cleared. The mask for this view is 0xF000_FF3E_0000_1983.
- R4: A write at 0x14E with the virtualization flag clear updates only the bits of the supervisor-view mask in the machine word. Bits 2 and 9 keep their old values.
- R5: With the virtualization flag set, reads and writes at 0x14E reach the guest copy, and the machine word is left unchanged.
- R6: The guest copy is stored under the supervisor-view mask, so its bits 2 and 9 always read as zero. It is also reachable directly at 0x24E.
- R7: Privilege is coded as 00 user, 01 supervisor, 11 machine and 10 reserved (treated like user). An access to 0x34E or 0x24E below machine level is illegal, and so is an access to 0x14E from user or reserved level. An illegal access raises `csr_illegal` in the same cycle, reads zero and changes no state.
- R8: After reset, both stored words are zero.
- R9: A read returns the stored value in the same cycle. A write becomes visible only after the next rising clock edge, so during the write cycle `csr_rdata` still shows the old value.
- R10: The decoded outputs of each word are as follows. `mode_en` is bits 2..0. `stack_emu` is bit 7. `trap_en` is {bit 9, bit 8}. `freeze_en` is {bit 12, bit 11}. `filter` is {bits 47..40, bits 37..33}. `custom` is bits 63..60. For the guest copy, `mode_en[2]` and `trap_en[1]` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | 1 | Access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | ADDR_W | CSR address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, combinational |
| csr_illegal | output | 1 | Access not permitted at current privilege |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization active |
| host_mode_en | output | 3 | Machine word mode enables |
| host_stack_emu | output | 1 | Machine word return-stack emulation |
| host_trap_en | output | 2 | Machine word trap recording enables |
| host_freeze_en | output | 2 | Machine word freeze triggers |
| host_filter | output | 13 | Machine word transfer-type filter bits |
| host_custom | output | 4 | Machine word custom field |
| guest_mode_en | output | 3 | Guest copy mode enables |
| guest_stack_emu | output | 1 | Guest copy return-stack emulation |
| guest_trap_en | output | 2 | Guest copy trap recording enables |
| guest_freeze_en | output | 2 | Guest copy freeze triggers |
| guest_filter | output | 13 | Guest copy transfer-type filter bits |
| guest_custom | output | 4 | Guest copy custom field |

## Verification
The bench builds the block with its default parameters: a 12-bit address and the three standard addresses. It adds 0x14F as a neighbouring address that maps to nothing. With these parameters the bench can cross every address with all four privilege codes and both values of the virtualization flag. It applies each combination with every walking-one data word and with several dense patterns. After each access it reads back both stored words and checks every decoded field. This exposes any mask bit that is wrong, any leak across the alias, and any write that slips past a privilege check.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

  localparam int unsigned DATA_W = 64;

  // Bit positions that the recording logic decodes
  localparam int unsigned BIT_MODE_M = 2;
  localparam int unsigned BIT_TRAP_M = 9;

  typedef enum logic [1:0] {
    PRV_U   = 2'b00,
    PRV_S   = 2'b01,
    PRV_RSV = 2'b10,
    PRV_M   = 2'b11
  } prv_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_HOST,
    TGT_SUPV,
    TGT_GUEST
  } tgt_e;

  // Contiguous run of ones from lo to hi inclusive
  function automatic logic [DATA_W-1:0] bit_span(input int lo, input int hi);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = lo; k <= hi; k++) m[k] = 1'b1;
    return m;
  endfunction

  // Every implemented field of the machine word
  function automatic logic [DATA_W-1:0] host_mask();
    return bit_span(0, 2) | bit_span(7, 9) | bit_span(11, 12) |
           bit_span(33, 37) | bit_span(40, 47) | bit_span(60, 63);
  endfunction

  // Machine word minus the machine-only controls
  function automatic logic [DATA_W-1:0] supv_mask();
    logic [DATA_W-1:0] m;
    m = host_mask();
    m[BIT_MODE_M] = 1'b0;
    m[BIT_TRAP_M] = 1'b0;
    return m;
  endfunction

  // Replace only the bits selected by m
  function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [DATA_W-1:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction

endpackage

// File: rtl/xrc_decode.sv
module xrc_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HOST_ADDR  = 12'h34E,
  parameter logic [ADDR_W-1:0] SUPV_ADDR  = 12'h14E,
  parameter logic [ADDR_W-1:0] GUEST_ADDR = 12'h24E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  xrc_pkg::prv_e     priv,
  input  logic              virt,
  output xrc_pkg::tgt_e     tgt,
  output logic              illegal,
  output logic              wr_host,
  output logic              wr_supv,
  output logic              wr_guest
);
  import xrc_pkg::*;

  logic hit_host, hit_supv, hit_guest;
  logic need_m, need_s, prv_is_m, prv_ge_s, grant;

  assign hit_host  = (addr == HOST_ADDR);
  assign hit_supv  = (addr == SUPV_ADDR);
  assign hit_guest = (addr == GUEST_ADDR);

  always_comb begin
    tgt = TGT_NONE;
    if (hit_host)       tgt = TGT_HOST;
    else if (hit_supv)  tgt = virt ? TGT_GUEST : TGT_SUPV;
    else if (hit_guest) tgt = TGT_GUEST;
  end

  assign need_m   = hit_host | hit_guest;
  assign need_s   = hit_supv;
  assign prv_is_m = (priv == PRV_M);
  assign prv_ge_s = (priv == PRV_M) || (priv == PRV_S);

  assign illegal  = sel & ((need_m & ~prv_is_m) | (need_s & ~prv_ge_s));
  assign grant    = sel & ~illegal;

  assign wr_host  = grant & we & (tgt == TGT_HOST);
  assign wr_supv  = grant & we & (tgt == TGT_SUPV);
  assign wr_guest = grant & we & (tgt == TGT_GUEST);

  // R1: at most one storage target per access
  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_host, wr_supv, wr_guest}));

  // R7: a refused access never produces a write strobe
  assert_no_write_when_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(wr_host || wr_supv || wr_guest));

endmodule

// File: rtl/xrc_word.sv
module xrc_word #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wen,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] eff_mask;
  assign eff_mask = wmask & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (wen) q <= xrc_pkg::merge_bits(q, wdata, eff_mask);
  end

  // R2: unimplemented positions never hold a one
  assert_reserved_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP) == '0);

endmodule

// File: rtl/xrc_fields.sv
module xrc_fields #(
  parameter bit HAS_M = 1'b1
) (
  input  logic [63:0] word,
  output logic [2:0]  mode_en,
  output logic        stack_emu,
  output logic [1:0]  trap_en,
  output logic [1:0]  freeze_en,
  output logic [12:0] filter,
  output logic [3:0]  custom
);
  assign mode_en[1:0] = word[1:0];
  assign stack_emu    = word[7];
  assign trap_en[0]   = word[8];
  assign freeze_en    = word[12:11];
  assign filter       = {word[47:40], word[37:33]};
  assign custom       = word[63:60];

  generate
    if (HAS_M) begin : g_mbits
      assign mode_en[2] = word[2];
      assign trap_en[1] = word[9];
    end else begin : g_no_mbits
      logic unused_mbits;
      assign unused_mbits = word[2] ^ word[9];
      assign mode_en[2] = 1'b0;
      assign trap_en[1] = 1'b0;
    end
  endgenerate

  logic unused_rsv;
  assign unused_rsv = ^{word[6:3], word[10], word[32:13], word[39:38], word[59:48]};

endmodule

// File: rtl/xfer_rec_ctl_bank.sv
module xfer_rec_ctl_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HOST_ADDR  = 12'h34E,
  parameter logic [ADDR_W-1:0] SUPV_ADDR  = 12'h14E,
  parameter logic [ADDR_W-1:0] GUEST_ADDR = 12'h24E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_sel,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              csr_illegal,
  input  logic [1:0]        cur_priv,
  input  logic              virt_on,
  output logic [2:0]        host_mode_en,
  output logic              host_stack_emu,
  output logic [1:0]        host_trap_en,
  output logic [1:0]        host_freeze_en,
  output logic [12:0]       host_filter,
  output logic [3:0]        host_custom,
  output logic [2:0]        guest_mode_en,
  output logic              guest_stack_emu,
  output logic [1:0]        guest_trap_en,
  output logic [1:0]        guest_freeze_en,
  output logic [12:0]       guest_filter,
  output logic [3:0]        guest_custom
);
  import xrc_pkg::*;

  localparam int unsigned W = DATA_W;
  localparam logic [W-1:0] HOST_M = host_mask();
  localparam logic [W-1:0] SUPV_M = supv_mask();

  tgt_e         tgt;
  logic         wr_host, wr_supv, wr_guest;
  logic [W-1:0] host_q, guest_q;
  logic [W-1:0] host_wmask;

  xrc_decode #(
    .ADDR_W(ADDR_W), .HOST_ADDR(HOST_ADDR),
    .SUPV_ADDR(SUPV_ADDR), .GUEST_ADDR(GUEST_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .sel(csr_sel), .we(csr_we), .addr(csr_addr),
    .priv(prv_e'(cur_priv)), .virt(virt_on), .tgt(tgt), .illegal(csr_illegal),
    .wr_host(wr_host), .wr_supv(wr_supv), .wr_guest(wr_guest)
  );

  // Machine writes cover all fields; supervisor writes skip the machine-only bits
  assign host_wmask = wr_host ? HOST_M : (wr_supv ? SUPV_M : '0);

  xrc_word #(.W(W), .KEEP(HOST_M)) u_host (
    .clk(clk), .rst_n(rst_n), .wen(wr_host | wr_supv),
    .wmask(host_wmask), .wdata(csr_wdata), .q(host_q)
  );

  xrc_word #(.W(W), .KEEP(SUPV_M)) u_guest (
    .clk(clk), .rst_n(rst_n), .wen(wr_guest),
    .wmask(SUPV_M), .wdata(csr_wdata), .q(guest_q)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_sel && !csr_illegal) begin
      unique case (tgt)
        TGT_HOST:  csr_rdata = host_q & HOST_M;
        TGT_SUPV:  csr_rdata = host_q & SUPV_M;
        TGT_GUEST: csr_rdata = guest_q & SUPV_M;
        default:   csr_rdata = '0;
      endcase
    end
  end

  xrc_fields #(.HAS_M(1'b1)) u_host_fields (
    .word(host_q), .mode_en(host_mode_en), .stack_emu(host_stack_emu),
    .trap_en(host_trap_en), .freeze_en(host_freeze_en),
    .filter(host_filter), .custom(host_custom)
  );

  xrc_fields #(.HAS_M(1'b0)) u_guest_fields (
    .word(guest_q), .mode_en(guest_mode_en), .stack_emu(guest_stack_emu),
    .trap_en(guest_trap_en), .freeze_en(guest_freeze_en),
    .filter(guest_filter), .custom(guest_custom)
  );

  // R4: supervisor-view writes leave the machine-only bits alone
  assert_supv_keeps_mbits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_supv |=> (host_q[BIT_MODE_M] == $past(host_q[BIT_MODE_M])) &&
                (host_q[BIT_TRAP_M] == $past(host_q[BIT_TRAP_M])));

  // R5: a redirected supervisor access never touches the machine word
  assert_redirect_spares_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel && virt_on && csr_addr == SUPV_ADDR) |=> $stable(host_q));

  // R6: guest copy never carries the machine-only bits
  assert_guest_mbits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !guest_q[BIT_MODE_M] && !guest_q[BIT_TRAP_M]);

  // R7: refused access reads zero and leaves both words as they were
  assert_refused_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0);
  assert_refused_holds_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> $stable(host_q) && $stable(guest_q));

  // R9: a machine write lands exactly one edge later
  assert_host_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_host |=> host_q == ($past(csr_wdata) & HOST_M));

endmodule

// File: tb/xfer_rec_ctl_bank_bench.sv
module xfer_rec_ctl_bank_bench;
  localparam logic [11:0] A_HOST  = 12'h34E;
  localparam logic [11:0] A_SUPV  = 12'h14E;
  localparam logic [11:0] A_GUEST = 12'h24E;
  localparam logic [11:0] A_NONE  = 12'h14F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, csr_sel, csr_we, virt_on, csr_illegal;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic [1:0]  cur_priv;
  logic [2:0]  host_mode_en, guest_mode_en;
  logic        host_stack_emu, guest_stack_emu;
  logic [1:0]  host_trap_en, guest_trap_en, host_freeze_en, guest_freeze_en;
  logic [12:0] host_filter, guest_filter;
  logic [3:0]  host_custom, guest_custom;

  xfer_rec_ctl_bank u_xfer_rec_ctl_bank (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .cur_priv(cur_priv), .virt_on(virt_on),
    .host_mode_en(host_mode_en), .host_stack_emu(host_stack_emu),
    .host_trap_en(host_trap_en), .host_freeze_en(host_freeze_en),
    .host_filter(host_filter), .host_custom(host_custom),
    .guest_mode_en(guest_mode_en), .guest_stack_emu(guest_stack_emu),
    .guest_trap_en(guest_trap_en), .guest_freeze_en(guest_freeze_en),
    .guest_filter(guest_filter), .guest_custom(guest_custom)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [63:0] host_m, guest_m;

  function automatic bit implemented(int k);
    return (k <= 2) || (k >= 7 && k <= 9) || k == 11 || k == 12 ||
           (k >= 33 && k <= 37) || (k >= 40 && k <= 47) || k >= 60;
  endfunction

  function automatic logic [63:0] full_m();
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++) if (implemented(k)) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] supv_m();
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++) if (implemented(k) && k != 2 && k != 9) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] pat(int i);
    if (i < 64)  return 64'd1 << i;
    if (i == 64) return '1;
    if (i == 65) return 64'hAAAA_AAAA_AAAA_AAAA;
    if (i == 66) return 64'h5555_5555_5555_5555;
    return 64'h0;
  endfunction

  function automatic logic [11:0] addr_of(int ai);
    case (ai)
      0: return A_HOST;
      1: return A_SUPV;
      2: return A_GUEST;
      default: return A_NONE;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [11:0] a, logic [1:0] p, logic v, logic w, logic [63:0] d);
    bit mapped, need_m, ok, bad;
    logic [63:0] exp_rd;
    string tag;
    @(negedge clk);
    csr_sel = 1'b1; csr_we = w; csr_addr = a; cur_priv = p; virt_on = v; csr_wdata = d;
    #1;
    mapped = (a == A_HOST) || (a == A_SUPV) || (a == A_GUEST);
    need_m = (a == A_HOST) || (a == A_GUEST);
    ok     = need_m ? (p == 2'b11) : (p == 2'b01 || p == 2'b11);
    bad    = mapped && !ok;
    check("R7 illegal flag", {63'd0, csr_illegal}, {63'd0, bad});
    if (!mapped)             begin exp_rd = '0; tag = "R1 unmapped read"; end
    else if (bad)            begin exp_rd = '0; tag = "R7 refused read"; end
    else if (a == A_HOST)    begin exp_rd = host_m & full_m();  tag = "R2 machine read"; end
    else if (a == A_SUPV && !v) begin exp_rd = host_m & supv_m(); tag = "R3 supervisor view read"; end
    else if (a == A_SUPV)    begin exp_rd = guest_m & supv_m(); tag = "R5 redirected read"; end
    else                     begin exp_rd = guest_m & supv_m(); tag = "R6 guest read"; end
    if (w) tag = {tag, " R9 old value during write"};
    check(tag, csr_rdata, exp_rd);
    @(posedge clk);
    if (w && mapped && !bad) begin
      if (a == A_HOST) host_m = d & full_m();
      else if (a == A_SUPV && !v) host_m = (host_m & ~supv_m()) | (d & supv_m());
      else guest_m = d & supv_m();
    end
    @(negedge clk);
    csr_sel = 1'b0; csr_we = 1'b0;
  endtask

  task automatic peek();
    drive(A_HOST, 2'b11, 1'b0, 1'b0, '0);
    drive(A_GUEST, 2'b11, 1'b0, 1'b0, '0);
    check("R10 host mode_en",   {61'd0, host_mode_en},   {61'd0, host_m[2:0]});
    check("R10 host stack_emu", {63'd0, host_stack_emu}, {63'd0, host_m[7]});
    check("R10 host trap_en",   {62'd0, host_trap_en},   {62'd0, host_m[9], host_m[8]});
    check("R10 host freeze_en", {62'd0, host_freeze_en}, {62'd0, host_m[12], host_m[11]});
    check("R10 host filter",    {51'd0, host_filter},    {51'd0, host_m[47:40], host_m[37:33]});
    check("R10 host custom",    {60'd0, host_custom},    {60'd0, host_m[63:60]});
    check("R10 guest mode_en",  {61'd0, guest_mode_en},  {61'd0, 1'b0, guest_m[1:0]});
    check("R10 guest stack_emu", {63'd0, guest_stack_emu}, {63'd0, guest_m[7]});
    check("R10 guest trap_en",  {62'd0, guest_trap_en},  {62'd0, 1'b0, guest_m[8]});
    check("R10 guest freeze_en", {62'd0, guest_freeze_en}, {62'd0, guest_m[12], guest_m[11]});
    check("R10 guest filter",   {51'd0, guest_filter},   {51'd0, guest_m[47:40], guest_m[37:33]});
    check("R10 guest custom",   {60'd0, guest_custom},   {60'd0, guest_m[63:60]});
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    host_m = '0; guest_m = '0;
    rst_n = 1'b0; csr_sel = 1'b0; csr_we = 1'b0; csr_addr = '0;
    csr_wdata = '0; cur_priv = 2'b11; virt_on = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: both words zero out of reset
    check("R8 reset host word", {61'd0, host_mode_en}, 64'd0);
    peek();

    // R4: supervisor write of zeros keeps bits 2 and 9 set by machine
    drive(A_HOST, 2'b11, 1'b0, 1'b1, '1);
    drive(A_SUPV, 2'b01, 1'b0, 1'b1, '0);
    drive(A_HOST, 2'b11, 1'b0, 1'b0, '0);
    check("R4 machine-only bits kept", host_m, 64'h0000_0000_0000_0204);
    peek();

    // R5: redirected write reaches the guest copy only
    drive(A_SUPV, 2'b01, 1'b1, 1'b1, '1);
    check("R5 guest after redirect", guest_m, 64'hF000_FF3E_0000_1983);
    peek();

    // Sweep: address x privilege x virtualization x data pattern
    for (int i = 0; i < 68; i++)
      for (int ai = 0; ai < 4; ai++)
        for (int p = 0; p < 4; p++)
          for (int v = 0; v < 2; v++) begin
            drive(addr_of(ai), 2'(p), 1'(v), 1'b1, pat(i) ^ {60'd0, 2'(ai), 1'(v), 1'b0});
            peek();
          end

    report();
  end
endmodule